// File: doc/BRIEF.md
# Absolute to Physical Address Mapper

This block turns a 64-bit absolute address into a physical address while virtual translation is switched off. It sits in the load/store path beside the translation buffer and is selected when the processor works in absolute mode. Three mapping modes exist. Legacy mode keeps the low word and zero-extends it. Wide mode keeps the low `PA_BITS` bits and sign-extends them from bit `PA_BITS-1`. Narrow mode sorts the low word into a memory, I/O or firmware window, and each window has its own rule for filling the upper bits.

The block reports which window it picked on `region_o`. It also reports the access rights that an absolute access always receives: read, write and execute, with no fault. The parameter `REG_OUT` selects where the result appears. With `REG_OUT=1` the result is registered and shown with a `valid_o` strobe one cycle after `valid_i`. With `REG_OUT=0` the result follows the inputs in the same cycle.

Top module: `abs_phys_map`

## Requirements
- R1: With `wide_i`=1 and `legacy_i`=0, `phys_o` is `addr_i[PA_BITS-1:0]` sign-extended from bit `PA_BITS-1` to 64 bits, and `region_o`=3.
- R2: In narrow mode (`wide_i`=0, `legacy_i`=0) with `addr_i[31:28]` not equal to 4'hF, `region_o`=0 (memory) and `phys_o` is `addr_i[31:0]` zero-extended. Bits 63:32 of the input are ignored.
- R3: In narrow mode with `addr_i[31:28]`=4'hF and `addr_i[27:24]` not zero, `region_o`=1 (I/O) and `phys_o` is `addr_i[31:0]` sign-extended from bit 31.
- R4: In narrow mode with `addr_i[31:28]`=4'hF and `addr_i[27:24]`=0, `region_o`=2 (firmware). `phys_o` is `addr_i[31:0]` zero-extended, with every bit from `PA_BITS-4` up to 63 forced to 1.
- R5: With `legacy_i`=1, `phys_o` is `addr_i[31:0]` zero-extended and `region_o`=0, whatever the values of `wide_i` and the upper address bits.
- R6: `PA_BITS` must lie between 36 and 54. Any other value stops elaboration, and the largest legal value of 54 maps correctly.
- R7: `perm_o` is always 3'b111, with bit 2 = read, bit 1 = write and bit 0 = execute.
- R8: With `REG_OUT`=1, `valid_o` equals `valid_i` of the previous cycle, and `phys_o`/`region_o` show the mapping of the address presented with that `valid_i`. While `valid_i`=0 they hold their values.
- R9: With `REG_OUT`=1, a synchronous active-high `rst_i` clears `valid_o`, `region_o` and `phys_o` to zero.
- R10: With `REG_OUT`=0, `valid_o`, `region_o` and `phys_o` follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Address qualifier |
| addr_i | input | 64 | Absolute address |
| wide_i | input | 1 | Wide (64-bit) addressing mode |
| legacy_i | input | 1 | Legacy 32-bit mode, overrides `wide_i` |
| valid_o | output | 1 | Result qualifier |
| region_o | output | 2 | 0 memory, 1 I/O, 2 firmware, 3 wide |
| phys_o | output | 64 | Physical address |
| perm_o | output | 3 | Granted rights {read, write, execute} |

## Verification
On every cycle the assertions check properties that hold for each window on its own. Memory results have a zero upper word, I/O results have an all-ones upper word, firmware results carry the forced-ones field and the F0 prefix, and wide results are sign-consistent above bit `PA_BITS-2`. With registered outputs they also check the one-cycle strobe and the hold while `valid_i` is low. Only the bench scenarios can show which window a given address lands in. That includes the window edges around 32'hEFFFFFFF, 32'hF0000000, 32'hF0FFFFFF and 32'hF1000000, the priority of legacy mode over wide mode, the reset values and the mapping at the largest legal `PA_BITS`.

// File: rtl/abs_map_pkg.sv
package abs_map_pkg;
  typedef enum logic [1:0] {
    RG_MEM  = 2'd0,
    RG_IO   = 2'd1,
    RG_FW   = 2'd2,
    RG_WIDE = 2'd3
  } region_e;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  // rights order: {read, write, execute}
  localparam logic [2:0] RIGHTS_ALL = 3'b111;
endpackage

// File: rtl/abs_region_dec.sv
module abs_region_dec
  import abs_map_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output region_e           region_o
);
  logic top_all_ones;
  logic next_zero;

  assign top_all_ones = (word_i[31:28] == 4'hF);
  assign next_zero    = (word_i[27:24] == 4'h0);

  always_comb begin
    if (!top_all_ones)   region_o = RG_MEM;
    else if (!next_zero) region_o = RG_IO;
    else                 region_o = RG_FW;
  end
endmodule

// File: rtl/abs_extend.sv
module abs_extend
  import abs_map_pkg::*;
#(
  parameter int PA_BITS = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic              legacy_i,
  input  region_e           narrow_rg_i,
  output logic [ADDR_W-1:0] phys_o,
  output region_e           region_o
);
  localparam int          FILL_LSB = PA_BITS - 4;
  localparam logic [ADDR_W-1:0] FW_FILL = ~((64'd1 << FILL_LSB) - 64'd1);

  logic [ADDR_W-1:0] wide_val;
  logic [ADDR_W-1:0] zext_val;
  logic [ADDR_W-1:0] sext_val;

  // wide mode: keep PA_BITS bits, replicate the top kept bit upward
  for (genvar b = 0; b < ADDR_W; b++) begin : g_wide
    if (b < PA_BITS) begin : g_keep
      assign wide_val[b] = addr_i[b];
    end else begin : g_ext
      assign wide_val[b] = addr_i[PA_BITS-1];
    end
  end

  assign zext_val = {{(ADDR_W-WORD_W){1'b0}}, addr_i[WORD_W-1:0]};
  assign sext_val = {{(ADDR_W-WORD_W){addr_i[WORD_W-1]}}, addr_i[WORD_W-1:0]};

  always_comb begin
    if (legacy_i) begin
      phys_o   = zext_val;
      region_o = RG_MEM;
    end else if (wide_i) begin
      phys_o   = wide_val;
      region_o = RG_WIDE;
    end else begin
      region_o = narrow_rg_i;
      unique case (narrow_rg_i)
        RG_IO:   phys_o = sext_val;
        RG_FW:   phys_o = zext_val | FW_FILL;
        default: phys_o = zext_val;
      endcase
    end
  end
endmodule

// File: rtl/abs_out_stage.sv
module abs_out_stage
  import abs_map_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] phys_i,
  input  region_e           region_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic [1:0]        region_o
);
  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [ADDR_W-1:0] phys_q;
    logic [1:0]        rg_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        vld_q  <= 1'b0;
        phys_q <= '0;
        rg_q   <= 2'd0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          phys_q <= phys_i;
          rg_q   <= region_i;
        end
      end
    end

    assign valid_o  = vld_q;
    assign phys_o   = phys_q;
    assign region_o = rg_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_i;
    assign valid_o  = valid_i;
    assign phys_o   = phys_i;
    assign region_o = region_i;
  end
endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map
  import abs_map_pkg::*;
#(
  parameter int PA_BITS = 40,
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        valid_i,
  input  logic [63:0] addr_i,
  input  logic        wide_i,
  input  logic        legacy_i,
  output logic        valid_o,
  output logic [1:0]  region_o,
  output logic [63:0] phys_o,
  output logic [2:0]  perm_o
);
  // R6: legal physical width range
  if (PA_BITS > 54 || PA_BITS < 36) begin : g_bad_width
    $error("abs_phys_map: PA_BITS=%0d outside 36..54", PA_BITS);
  end

  region_e           narrow_rg;
  region_e           map_rg;
  logic [ADDR_W-1:0] map_phys;

  abs_region_dec u_dec (
    .word_i   (addr_i[WORD_W-1:0]),
    .region_o (narrow_rg)
  );

  abs_extend #(.PA_BITS(PA_BITS)) u_ext (
    .addr_i      (addr_i),
    .wide_i      (wide_i),
    .legacy_i    (legacy_i),
    .narrow_rg_i (narrow_rg),
    .phys_o      (map_phys),
    .region_o    (map_rg)
  );

  abs_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .valid_i  (valid_i),
    .phys_i   (map_phys),
    .region_i (map_rg),
    .valid_o  (valid_o),
    .phys_o   (phys_o),
    .region_o (region_o)
  );

  // R7: absolute accesses always carry full rights
  assign perm_o = RIGHTS_ALL;
endmodule

// File: rtl/abs_phys_map_chk.sv
module abs_phys_map_chk #(
  parameter int PA_BITS = 40,
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_i,
  input logic        valid_i,
  input logic        valid_o,
  input logic [1:0]  region_o,
  input logic [63:0] phys_o
);
  a_r2_mem_upper_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && region_o == 2'd0) |-> (phys_o[63:32] == 32'h0));

  a_r3_io_upper_ones: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && region_o == 2'd1) |-> (phys_o[63:32] == 32'hFFFF_FFFF));

  a_r4_fw_fill: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && region_o == 2'd2) |->
      ((&phys_o[63:PA_BITS-4]) && phys_o[31:24] == 8'hF0));

  a_r1_wide_sign: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && region_o == 2'd3) |->
      ((&phys_o[63:PA_BITS-1]) || !(|phys_o[63:PA_BITS-1])));

  if (REG_OUT) begin : g_reg_chk
    a_r8_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |=> valid_o);

    a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |=> !valid_o);

    a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |=> ($stable(phys_o) && $stable(region_o)));
  end
endmodule

bind abs_phys_map abs_phys_map_chk #(.PA_BITS(PA_BITS), .REG_OUT(REG_OUT)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .region_o (region_o),
  .phys_o   (phys_o)
);

// File: tb/abs_phys_map_tb_top.sv
module abs_phys_map_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [63:0] addr = '0;
  logic        wide = 1'b0;
  logic        legacy = 1'b0;

  logic        vo_r, vo_c, vo_m;
  logic [1:0]  rg_r, rg_c, rg_m;
  logic [63:0] ph_r, ph_c, ph_m;
  logic [2:0]  pm_r, pm_c, pm_m;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  abs_phys_map #(.PA_BITS(40), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .addr_i(addr), .wide_i(wide),
    .legacy_i(legacy), .valid_o(vo_r), .region_o(rg_r), .phys_o(ph_r), .perm_o(pm_r));

  abs_phys_map #(.PA_BITS(40), .REG_OUT(1'b0)) dut_c (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .addr_i(addr), .wide_i(wide),
    .legacy_i(legacy), .valid_o(vo_c), .region_o(rg_c), .phys_o(ph_c), .perm_o(pm_c));

  abs_phys_map #(.PA_BITS(54), .REG_OUT(1'b0)) dut_m (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .addr_i(addr), .wide_i(wide),
    .legacy_i(legacy), .valid_o(vo_m), .region_o(rg_m), .phys_o(ph_m), .perm_o(pm_m));

  typedef struct packed {
    logic        leg;
    logic        wid;
    logic [63:0] a;
    logic [1:0]  rg;
    logic [63:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 64'h0000_0000_EFFF_FFFF, 2'd0, 64'h0000_0000_EFFF_FFFF, 4'd2},
    '{1'b0, 1'b0, 64'h0000_0000_F000_0000, 2'd2, 64'hFFFF_FFF0_F000_0000, 4'd4},
    '{1'b0, 1'b0, 64'h0000_0000_F0FF_FFFF, 2'd2, 64'hFFFF_FFF0_F0FF_FFFF, 4'd4},
    '{1'b0, 1'b0, 64'h0000_0000_F100_0000, 2'd1, 64'hFFFF_FFFF_F100_0000, 4'd3},
    '{1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678, 2'd0, 64'h0000_0000_1234_5678, 4'd2},
    '{1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},
    '{1'b0, 1'b0, 64'h1234_5678_F0AB_CDEF, 2'd2, 64'hFFFF_FFF0_F0AB_CDEF, 4'd4},
    '{1'b0, 1'b1, 64'h0000_0080_0000_0000, 2'd3, 64'hFFFF_FF80_0000_0000, 4'd1},
    '{1'b0, 1'b1, 64'hABCD_EF7F_FFFF_FFFF, 2'd3, 64'h0000_007F_FFFF_FFFF, 4'd1},
    '{1'b0, 1'b1, 64'h0000_0000_0000_0000, 2'd3, 64'h0000_0000_0000_0000, 4'd1},
    '{1'b1, 1'b0, 64'h1111_2222_F000_0000, 2'd0, 64'h0000_0000_F000_0000, 4'd5},
    '{1'b1, 1'b1, 64'hFFFF_FFFF_F100_0000, 2'd0, 64'h0000_0000_F100_0000, 4'd5}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] held_ph;
    logic [1:0]  held_rg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", "valid_o", {63'd0, vo_r}, 64'd0);
    check("R9", "phys_o", ph_r, 64'd0);
    check("R9", "region_o", {62'd0, rg_r}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      legacy  = VEC[i].leg;
      wide    = VEC[i].wid;
      addr    = VEC[i].a;
      valid_i = 1'b1;
      #1;
      // R10: combinational variant follows in the same cycle
      check("R10", "comb valid", {63'd0, vo_c}, 64'd1);
      check(tag_name(VEC[i].tag), "comb phys", ph_c, VEC[i].exp);
      check(tag_name(VEC[i].tag), "comb region", {62'd0, rg_c}, {62'd0, VEC[i].rg});
      @(negedge clk);
      // R8: registered result one cycle later
      check("R8", "reg valid", {63'd0, vo_r}, 64'd1);
      check(tag_name(VEC[i].tag), "reg phys", ph_r, VEC[i].exp);
      check(tag_name(VEC[i].tag), "reg region", {62'd0, rg_r}, {62'd0, VEC[i].rg});
    end

    // R8: hold while valid_i is low
    held_ph = ph_r;
    held_rg = rg_r;
    valid_i = 1'b0;
    legacy  = 1'b0;
    wide    = 1'b0;
    addr    = 64'h0000_0000_F200_0000;
    @(negedge clk);
    check("R8", "valid low", {63'd0, vo_r}, 64'd0);
    check("R8", "phys held", ph_r, held_ph);
    check("R8", "region held", {62'd0, rg_r}, {62'd0, held_rg});
    check("R10", "comb valid low", {63'd0, vo_c}, 64'd0);

    // R7: full rights on all variants
    check("R7", "perm reg", {61'd0, pm_r}, 64'd7);
    check("R7", "perm comb", {61'd0, pm_c}, 64'd7);

    // R6: largest legal width, wide sign extension and firmware fill
    wide = 1'b1;
    addr = 64'h0020_0000_0000_0000;
    #1;
    check("R6", "w54 wide phys", ph_m, 64'hFFE0_0000_0000_0000);
    wide = 1'b0;
    addr = 64'h0000_0000_F000_0000;
    #1;
    check("R6", "w54 fw phys", ph_m, 64'hFFFC_0000_F000_0000);
    check("R6", "w54 fw region", {62'd0, rg_m}, 64'd2);

    // R9: reset in mid-run clears registered outputs
    valid_i = 1'b1;
    addr    = 64'h0000_0000_F100_0000;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "valid after rst", {63'd0, vo_r}, 64'd0);
    check("R9", "phys after rst", ph_r, 64'd0);
    check("R9", "region after rst", {62'd0, rg_r}, 64'd0);
    rst = 1'b0;
    valid_i = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule